// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block turns the status of a UART's transmit and receive paths into the single interrupt pin that a host processor watches. The conditions it applies depend on the FIFO-enable control bit. With FIFOs off, it looks at whether the one-byte holding registers are empty or full. With FIFOs on, it compares the FIFO fill levels against programmable trigger thresholds, and it also honours a receive data-timeout flag. Each of the two sources has its own enable bit. The two gated conditions are ORed into one "interrupt wanted" signal.

The wanted signal feeds a two-state machine. Its states are `IRQ_QUIET` and `IRQ_RAISED`. The transition QUIET→RAISED (`go_raise`) is taken on a clock edge where the wanted signal is high. The transition RAISED→QUIET (`go_lower`) is taken on an edge where it is low. All other edges keep the current state. Reset forces `IRQ_QUIET`. The pin outputs are decoded from the state register alone, so they change exactly one clock after the status inputs and cannot glitch.

The bus-mode select sets the pin's polarity and drive style. In the host-high mode the pin is always driven, high while active. In the host-low mode the pin uses an open-drain style: it drives low only while active and is otherwise released, so an external pull-up holds it high. The pad is modelled as a data bit (`irq_o`) and a drive enable (`irq_oe`).

Top module: `uart_irq_out`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state is `IRQ_QUIET` and the pin is inactive: with `bus_hi_mode`=1 the outputs are `irq_o`=0 and `irq_oe`=1, and with `bus_hi_mode`=0 they are `irq_o`=0 and `irq_oe`=0.
- R2: With `fifo_en`=0 and `tx_ie`=1, the transmit condition is true exactly when `tx_level`==0 (holding register empty). It is false when the level is nonzero (one byte held).
- R3: With `fifo_en`=1 and `tx_ie`=1, the transmit condition is true when `tx_level`==0 or `tx_level` < `tx_trig`. It is false when `tx_level` >= `tx_trig` and `tx_level` != 0.
- R4: With `fifo_en`=0 and `rx_ie`=1, the receive condition is true exactly when `rx_level` != 0 (holding register full).
- R5: With `fifo_en`=1 and `rx_ie`=1, the receive condition is true when `rx_level` >= `rx_trig` or `rx_timeout`=1. Otherwise it is false.
- R6: With `fifo_en`=0, `rx_timeout` has no effect on the pin.
- R7: Each condition counts only when its own enable bit is 1. With both enables at 0, the pin goes inactive whatever the levels and the timeout are.
- R8: The pin reflects the inputs sampled at the previous rising clock edge, one cycle of latency. Between edges it does not change.
- R9: When `bus_hi_mode`=1, `irq_oe` is 1 and `irq_o` is 1 exactly when the interrupt is active.
- R10: When `bus_hi_mode`=0, `irq_o` is 0 and `irq_oe` is 1 exactly when the interrupt is active (drive low). When inactive, `irq_oe` is 0 (released).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO-enable control bit: 1 = trigger-level rules, 0 = holding-register rules |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_level | input | LVL_W (6) | Transmit FIFO or holding-register fill count |
| rx_level | input | LVL_W (6) | Receive FIFO or holding-register fill count |
| tx_trig | input | LVL_W (6) | Transmit trigger threshold |
| rx_trig | input | LVL_W (6) | Receive trigger threshold |
| rx_timeout | input | 1 | Receive data-timeout flag |
| bus_hi_mode | input | 1 | 1 = always-driven active-high pin, 0 = open-drain active-low pin |
| irq_o | output | 1 | Pad data bit |
| irq_oe | output | 1 | Pad drive enable |

## Verification
Several behaviours are checked by assertions on every cycle. These are the pin encoding in each bus mode, the one-cycle latency of the state machine, the holding-register rules for transmit and receive, the timeout raising the pin in FIFO mode, and the pin dropping when both enables are off. The bench scenarios are needed for the rest. They show the trigger comparisons at their exact boundaries (level one below, equal to, and at the full depth of 32), the timeout being ignored with FIFOs off, the released pin during reset in the open-drain mode, and the absence of any change between clock edges.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/uirq_tx_cond.sv
module uirq_tx_cond #(
    parameter int LVL_W = 6
) (
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             hit
);
    logic empty;
    assign empty = (level == '0);

    always_comb begin
        if (fifo_en) hit = empty || (level < trig);   // R3
        else         hit = empty;                     // R2
    end
endmodule

// File: rtl/uirq_rx_cond.sv
module uirq_rx_cond #(
    parameter int LVL_W = 6
) (
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  logic             timeout,
    output logic             hit
);
    always_comb begin
        if (fifo_en) hit = (level >= trig) || timeout; // R5
        else         hit = (level != '0);              // R4, R6: timeout unused
    end
endmodule

// File: rtl/uirq_pin_fsm.sv
module uirq_pin_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic bus_hi_mode,
    output logic irq_o,
    output logic irq_oe
);
    irq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET:  if (want)  state_nx = IRQ_RAISED; // go_raise
            IRQ_RAISED: if (!want) state_nx = IRQ_QUIET;  // go_lower
            default:    state_nx = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            IRQ_RAISED: begin
                irq_o  = bus_hi_mode;
                irq_oe = 1'b1;
            end
            default: begin
                irq_o  = 1'b0;
                irq_oe = bus_hi_mode;
            end
        endcase
    end

    AST_WANT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        want |=> (state == IRQ_RAISED)); // R8
    AST_NOWANT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        !want |=> (state == IRQ_QUIET)); // R8
    AST_HI_MODE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hi_mode |-> (irq_oe && (irq_o == (state == IRQ_RAISED)))); // R9
    AST_LO_MODE_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hi_mode |-> (!irq_o && (irq_oe == (state == IRQ_RAISED)))); // R10
endmodule

// File: rtl/uart_irq_out.sv
module uart_irq_out #(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             tx_ie,
    input  logic             rx_ie,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             bus_hi_mode,
    output logic             irq_o,
    output logic             irq_oe
);
    logic tx_hit, rx_hit, want;

    uirq_tx_cond #(.LVL_W(LVL_W)) u_tx (
        .fifo_en (fifo_en),
        .level   (tx_level),
        .trig    (tx_trig),
        .hit     (tx_hit)
    );

    uirq_rx_cond #(.LVL_W(LVL_W)) u_rx (
        .fifo_en (fifo_en),
        .level   (rx_level),
        .trig    (rx_trig),
        .timeout (rx_timeout),
        .hit     (rx_hit)
    );

    assign want = (tx_ie && tx_hit) || (rx_ie && rx_hit); // R7

    uirq_pin_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .want        (want),
        .bus_hi_mode (bus_hi_mode),
        .irq_o       (irq_o),
        .irq_oe      (irq_oe)
    );

    logic pin_active;
    assign pin_active = bus_hi_mode ? irq_o : irq_oe;

    AST_TX_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_ie && tx_level == '0) |=> pin_active); // R2
    AST_TX_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_ie && !rx_ie && tx_level != '0) |=> !pin_active); // R2
    AST_RX_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_ie && rx_level != '0) |=> pin_active); // R4
    AST_RX_TIMEOUT_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_ie && rx_timeout) |=> pin_active); // R5
    AST_TIMEOUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_ie && !tx_ie && rx_level == '0) |=> !pin_active); // R6
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !rx_ie) |=> !pin_active); // R7
endmodule

// File: tb/sim_uart_irq_out.sv
module sim_uart_irq_out;
    localparam int W = 6;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 0, tx_ie = 0, rx_ie = 0, rx_timeout = 0, bus_hi_mode = 1;
    logic [W-1:0] tx_level = '0, rx_level = '0, tx_trig = '0, rx_trig = '0;
    logic irq_o, irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    uart_irq_out u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
        .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .bus_hi_mode(bus_hi_mode), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    // fields: req[34:31] fe tie rie tl rl tt rt tmo hi eo eoe
    function automatic logic [34:0] mk(input logic [3:0] req, input logic fe, tie, rie,
                                       input logic [5:0] tl, rl, tt, rt,
                                       input logic tmo, hi, eo, eoe);
        return {req, fe, tie, rie, tl, rl, tt, rt, tmo, hi, eo, eoe};
    endfunction

    localparam logic [34:0] VEC [NV] = '{
        mk(2, 0,1,0,  0, 0, 0, 0, 0,1, 1,1),  // R2 holding empty
        mk(2, 0,1,0,  1, 0, 0, 0, 0,1, 0,1),  // R2 holding full
        mk(4, 0,0,1,  1, 1, 0, 0, 0,1, 1,1),  // R4 holding full
        mk(6, 0,0,1,  1, 0, 0, 8, 1,1, 0,1),  // R6 timeout ignored
        mk(3, 1,1,0,  3, 0, 8, 0, 0,1, 1,1),  // R3 below trigger
        mk(3, 1,1,0,  8, 0, 8, 0, 0,1, 0,1),  // R3 equal trigger
        mk(3, 1,1,0,  0, 0, 0, 0, 0,1, 1,1),  // R3 empty
        mk(5, 1,0,1,  5, 8, 0, 8, 0,1, 1,1),  // R5 at trigger
        mk(5, 1,0,1,  5, 7, 0, 8, 0,1, 0,1),  // R5 one below
        mk(5, 1,0,1,  5, 2, 0, 8, 1,1, 1,1),  // R5 timeout
        mk(5, 1,0,1,  5,32, 0,32, 0,1, 1,1),  // R5 full depth
        mk(7, 1,0,0,  0,32, 8, 8, 1,1, 0,1),  // R7 all masked
        mk(7, 1,1,0, 20,32, 8, 8, 1,1, 0,1),  // R7 rx masked
        mk(10,0,1,0,  0, 0, 0, 0, 0,0, 0,1),  // R10 drive low
        mk(10,0,1,0,  1, 0, 0, 0, 0,0, 0,0),  // R10 released
        mk(9, 0,1,0,  1, 0, 0, 0, 0,1, 0,1)   // R9 driven low inactive
    };

    task automatic check(input string req, input logic eo, input logic eoe);
        checks++;
        if (irq_o !== eo || irq_oe !== eoe) begin
            errors++;
            $display("FAIL %s: irq_o=%b irq_oe=%b expected irq_o=%b irq_oe=%b",
                     req, irq_o, irq_oe, eo, eoe);
        end
    endtask

    task automatic apply(input logic [34:0] v);
        {fifo_en, tx_ie, rx_ie, tx_level, rx_level, tx_trig, rx_trig,
         rx_timeout, bus_hi_mode} = v[33:2];
    endtask

    initial begin
        // R1: reset state in both modes
        bus_hi_mode = 1; tx_ie = 1; // tx condition true, held off by reset
        repeat (2) @(negedge clk);
        check("R1", 1'b0, 1'b1);
        bus_hi_mode = 0;
        #1 check("R1", 1'b0, 1'b0);
        tx_ie = 0; bus_hi_mode = 1;
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        check("R1", 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][34:31]), VEC[i][1], VEC[i][0]);
        end

        // R8: inactive, then make condition true; no change until the edge
        bus_hi_mode = 1; fifo_en = 0; rx_ie = 0; tx_ie = 1; tx_level = 1;
        @(posedge clk); @(negedge clk);
        check("R8", 1'b0, 1'b1);
        tx_level = 0;
        #1 check("R8", 1'b0, 1'b1);
        @(posedge clk); #1 check("R8", 1'b1, 1'b1);
        tx_level = 1;
        #1 check("R8", 1'b1, 1'b1);
        @(posedge clk); #1 check("R8", 1'b0, 1'b1);

        // R1: reset while active in open-drain mode releases the pin
        @(negedge clk) bus_hi_mode = 0; tx_level = 0;
        @(posedge clk); @(negedge clk);
        check("R10", 1'b0, 1'b1);
        rst_n = 0;
        #1 check("R1", 1'b0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule